// File: doc/BRIEF.md
# LED Pixel Controller Register Frontend

This block is the register-facing half of a serial RGB LED pixel controller. Software, or a DMA engine, writes 32-bit pixel words into a data register. Each write is queued in a pixel FIFO. The waveform generator downstream drains the FIFO through a valid/ready pair. The block also holds the configuration words that the generator consumes: the control word, the bit-timing word and the reset-timing word. It exports them with their reserved bits forced to zero.

A refill request output stays high while the FIFO has at least as many free entries as a programmable trigger level. With the default level of half the depth, a requester that sees the request can always write a half-depth burst without loss. The rising edge of that request, and a done pulse from the waveform generator, each latch a status bit. Each status bit has its own enable. A global enable gates the combined interrupt line. Software clears status bits by writing ones to them.

Top module: `ledc_frontend`

## Requirements
- R1: After reset the FIFO is empty (`pix_valid_o` low), all status bits and interrupt enables are zero, the trigger level reads 16, and `irq_o` is low.
- R2: Each write to offset 0x14 pushes one word. `pix_data_o` shows the oldest queued word while `pix_valid_o` is high. A cycle with `pix_ready_i` and `pix_valid_o` both high removes that word, so words leave in the order they were written.
- R3: A write to offset 0x14 while 32 words are queued is discarded and leaves the queued words unchanged. It also sets the sticky overflow status bit, bit 2 of offset 0x20, which stays set until software clears it.
- R4: `dreq_o` is high exactly when the free entry count (32 minus queued words) is greater than or equal to the trigger level.
- R5: Status bit 1 of offset 0x20 sets on the clock edge after `dreq_o` goes from low to high. A request that stays high does not set it again.
- R6: Status bit 0 of offset 0x20 sets on the clock edge that samples `xfer_done_i` high.
- R7: Writing offset 0x20 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged. A set event in the same cycle wins over the clear.
- R8: `irq_o` equals the global enable (bit 5 of offset 0x1C) AND the OR of status bits 1:0 masked by enable bits 1:0 of offset 0x1C. The overflow bit never raises `irq_o`.
- R9: Configuration words read back masked: offset 0x00 keeps bits 28:16, 8:6 and 0; offset 0x04 keeps bits 26:16 and 10:0; offset 0x0C keeps all 32 bits; offset 0x1C keeps bits 5, 1 and 0. A read of offset 0x14 returns zero.
- R10: Offset 0x18 holds the trigger level in bits 4:0 and reads zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| pix_data_o | output | 32 | Oldest queued pixel word |
| pix_valid_o | output | 1 | FIFO holds at least one word |
| pix_ready_i | input | 1 | Generator takes the presented word |
| xfer_done_i | input | 1 | One-cycle pulse: frame finished |
| ctrl_o | output | 32 | Masked control word |
| timing_o | output | 32 | Masked bit-timing word |
| rst_timing_o | output | 32 | Reset-timing word |
| dreq_o | output | 1 | Refill request |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest state to reach from the ports is a true rising edge of the refill request. The request is already high out of reset, so it can only rise again after the FIFO has been filled past the trigger level and then drained back down to it. The stimulus therefore fills the FIFO to capacity and pushes one more word to provoke the overflow. It then drains the FIFO word by word and watches the request and its status bit around the sixteenth pop. The same drained state is then reused to check interrupt masking, and to check a clear that collides with a done pulse.

// File: rtl/ledc_fe_pkg.sv
package ledc_fe_pkg;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_TIM  = 8'h04;
  localparam logic [7:0] A_RSTT = 8'h0C;
  localparam logic [7:0] A_DATA = 8'h14;
  localparam logic [7:0] A_TRIG = 8'h18;
  localparam logic [7:0] A_IEN  = 8'h1C;
  localparam logic [7:0] A_STAT = 8'h20;

  localparam logic [31:0] M_CTRL = 32'h1FFF_01C1;
  localparam logic [31:0] M_TIM  = 32'h07FF_07FF;

  // status bit order: {overflow, data request, transfer finish}
  localparam int ST_FIN  = 0;
  localparam int ST_DREQ = 1;
  localparam int ST_OVF  = 2;

  function automatic int unsigned free_slots(int unsigned depth, int unsigned used);
    return (used >= depth) ? 0 : depth - used;
  endfunction

  function automatic logic irq_fn(logic gen, logic [1:0] en, logic [1:0] st);
    return gen & |(en & st);
  endfunction
endpackage

// File: rtl/ledc_fe_fifo.sv
module ledc_fe_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CW-1:0]    used_o,
  output logic             drop_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] used_q;
  logic push_ok, pop_ok;

  assign empty_o = (used_q == '0);
  assign full_o  = (used_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign drop_o  = push_i && full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign used_o  = used_q;
  assign data_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   used_q <= used_q + CW'(1);
        2'b01:   used_q <= used_q - CW'(1);
        default: used_q <= used_q;
      endcase
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    used_o <= CW'(DEPTH));
  p_push_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (used_o == $past(used_o) + CW'(1)));
  p_drop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_o && !pop_i) |=> (used_o == CW'(DEPTH)));
endmodule

// File: rtl/ledc_fe_req.sv
module ledc_fe_req #(
  parameter int DEPTH = 32,
  parameter int TW = 5,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] used_i,
  input  logic [TW-1:0] trig_i,
  output logic          dreq_o,
  output logic          rise_o
);
  import ledc_fe_pkg::*;
  logic req_q;

  assign dreq_o = free_slots(DEPTH, 32'(used_i)) >= 32'(trig_i);
  assign rise_o = dreq_o && !req_q;

  // Reset high: the request is already up when reset lifts, which is no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b1;
    else        req_q <= dreq_o;
  end

  p_full_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((used_i == CW'(DEPTH)) && (trig_i != '0)) |-> !dreq_o);
  p_rise_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ledc_fe_irq.sv
module ledc_fe_irq #(
  parameter int NST = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NST-1:0] set_i,
  input  logic           clr_wr_i,
  input  logic [NST-1:0] clr_data_i,
  input  logic [1:0]     en_i,
  input  logic           gen_i,
  output logic [NST-1:0] status_o,
  output logic           irq_o
);
  import ledc_fe_pkg::*;
  logic [NST-1:0] st_q, clr_mask;

  assign clr_mask = clr_wr_i ? clr_data_i : '0;
  assign status_o = st_q;
  assign irq_o    = irq_fn(gen_i, en_i, st_q[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr_mask) | set_i;
  end

  p_fin_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[ST_FIN] |=> status_o[ST_FIN]);
  p_dreq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[ST_DREQ] |=> status_o[ST_DREQ]);
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[ST_OVF] && !clr_mask[ST_OVF]) |=> status_o[ST_OVF]);
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_i |-> !irq_o);
endmodule

// File: rtl/ledc_frontend.sv
module ledc_frontend #(
  parameter int DEPTH = 32,
  parameter int TRIG_W = 5,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic [31:0] pix_data_o,
  output logic        pix_valid_o,
  input  logic        pix_ready_i,
  input  logic        xfer_done_i,
  output logic [31:0] ctrl_o,
  output logic [31:0] timing_o,
  output logic [31:0] rst_timing_o,
  output logic        dreq_o,
  output logic        irq_o
);
  import ledc_fe_pkg::*;

  logic [31:0] ctrl_q, tim_q, rstt_q;
  logic [TRIG_W-1:0] trig_q;
  logic gen_q;
  logic [1:0] en_q;
  logic data_wr, stat_wr, fifo_empty, fifo_full, fifo_drop, dreq_rise;
  logic [CW-1:0] fifo_used;
  logic [2:0] st_set, status;

  assign data_wr = reg_wr_i && (reg_addr_i == A_DATA);
  assign stat_wr = reg_wr_i && (reg_addr_i == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tim_q  <= '0;
      rstt_q <= '0;
      trig_q <= TRIG_W'(DEPTH / 2);
      gen_q  <= 1'b0;
      en_q   <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        A_CTRL: ctrl_q <= reg_wdata_i & M_CTRL;
        A_TIM:  tim_q  <= reg_wdata_i & M_TIM;
        A_RSTT: rstt_q <= reg_wdata_i;
        A_TRIG: trig_q <= reg_wdata_i[TRIG_W-1:0];
        A_IEN: begin
          gen_q <= reg_wdata_i[5];
          en_q  <= reg_wdata_i[1:0];
        end
        default: ;
      endcase
    end
  end

  ledc_fe_fifo #(.DEPTH(DEPTH), .WIDTH(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(data_wr), .data_i(reg_wdata_i),
    .pop_i(pix_ready_i), .data_o(pix_data_o), .empty_o(fifo_empty),
    .full_o(fifo_full), .used_o(fifo_used), .drop_o(fifo_drop)
  );

  ledc_fe_req #(.DEPTH(DEPTH), .TW(TRIG_W)) u_req (
    .clk(clk), .rst_n(rst_n), .used_i(fifo_used), .trig_i(trig_q),
    .dreq_o(dreq_o), .rise_o(dreq_rise)
  );

  always_comb begin
    st_set = '0;
    st_set[ST_FIN]  = xfer_done_i;
    st_set[ST_DREQ] = dreq_rise;
    st_set[ST_OVF]  = fifo_drop;
  end

  ledc_fe_irq #(.NST(3)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(st_set), .clr_wr_i(stat_wr),
    .clr_data_i(reg_wdata_i[2:0]), .en_i(en_q), .gen_i(gen_q),
    .status_o(status), .irq_o(irq_o)
  );

  assign pix_valid_o  = !fifo_empty;
  assign ctrl_o       = ctrl_q;
  assign timing_o     = tim_q;
  assign rst_timing_o = rstt_q;

  always_comb begin
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_q;
      A_TIM:   reg_rdata_o = tim_q;
      A_RSTT:  reg_rdata_o = rstt_q;
      A_TRIG:  reg_rdata_o = {{(32-TRIG_W){1'b0}}, trig_q};
      A_IEN:   reg_rdata_o = {26'b0, gen_q, 3'b0, en_q};
      A_STAT:  reg_rdata_o = {29'b0, status};
      default: reg_rdata_o = '0;
    endcase
  end

  p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && fifo_full) |=> status[ST_OVF]);
  p_dreq_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq_o) |=> status[ST_DREQ]);
endmodule

// File: tb/ledc_frontend_tb_top.sv
module ledc_frontend_tb_top;
  localparam int CLK_NS = 10;
  localparam int WDOG = 20000;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, pix_ready = 0, xfer_done = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata, pix_data, ctrl, timing, rst_timing;
  logic pix_valid, dreq, irq;
  int errors = 0, checks = 0;

  always #(CLK_NS/2) clk = ~clk;

  ledc_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .pix_data_o(pix_data),
    .pix_valid_o(pix_valid), .pix_ready_i(pix_ready), .xfer_done_i(xfer_done),
    .ctrl_o(ctrl), .timing_o(timing), .rst_timing_o(rst_timing),
    .dreq_o(dreq), .irq_o(irq)
  );

  // {addr, write data, expected readback}
  localparam logic [71:0] VEC [7] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h1FFF_01C1},  // R9
    {8'h04, 32'hFFFF_FFFF, 32'h07FF_07FF},  // R9
    {8'h0C, 32'h1234_5678, 32'h1234_5678},  // R9
    {8'h18, 32'hFFFF_FFFF, 32'h0000_001F},  // R10
    {8'h1C, 32'hFFFF_FFFF, 32'h0000_0023},  // R9
    {8'h1C, 32'h0000_0000, 32'h0000_0000},  // R9
    {8'h18, 32'h0000_0010, 32'h0000_0010}   // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic pop_chk(input logic [31:0] exp);
    @(negedge clk);
    chk("R2 pop data", pix_data, exp);
    chk("R2 pop valid", 32'(pix_valid), 32'd1);
    pix_ready = 1;
    @(negedge clk);
    pix_ready = 0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 valid", 32'(pix_valid), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R4 dreq empty", 32'(dreq), 1);
    rd(8'h20, v); chk("R1 status", v, 0);
    rd(8'h18, v); chk("R1 trig", v, 32'h10);
    rd(8'h1C, v); chk("R1 ien", v, 0);

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk("R9/R10 readback", v, VEC[i][31:0]);
    end
    chk("R9 ctrl port", ctrl, 32'h1FFF_01C1);
    rd(8'h14, v); chk("R9 data reads zero", v, 0);
    rd(8'h20, v); chk("R5 no spurious dreq", v, 0);

    // fill, watching the request around the trigger level
    for (int i = 0; i < 32; i++) begin
      wr(8'h14, 32'hA000_0000 + 32'(i));
      if (i == 15) chk("R4 free16 trig16", 32'(dreq), 1);
      if (i == 16) chk("R4 free15 trig16", 32'(dreq), 0);
    end
    rd(8'h20, v); chk("R5 no rise while filling", v, 0);
    wr(8'h14, 32'hDEAD_BEEF);
    rd(8'h20, v); chk("R3 overflow flag", v, 32'h4);
    chk("R4 full no dreq", 32'(dreq), 0);

    for (int i = 0; i < 32; i++) begin
      pop_chk(32'hA000_0000 + 32'(i));
      if (i == 14) chk("R4 17 used", 32'(dreq), 0);
      if (i == 15) begin
        chk("R4 16 used", 32'(dreq), 1);
        chk("R5 status lags edge", reg_rdata & 32'h2, 0);
      end
    end
    @(negedge clk);
    chk("R3 dropped word absent", 32'(pix_valid), 0);
    rd(8'h20, v); chk("R5 dreq status set", v, 32'h6);

    wr(8'h1C, 32'h22); @(negedge clk); chk("R8 irq enabled", 32'(irq), 1);
    wr(8'h1C, 32'h02); @(negedge clk); chk("R8 global off", 32'(irq), 0);
    wr(8'h20, 32'h0);  rd(8'h20, v); chk("R7 zero write keeps", v, 32'h6);
    wr(8'h20, 32'h2);  rd(8'h20, v); chk("R7 clear dreq", v, 32'h4);
    wr(8'h1C, 32'h23); @(negedge clk); chk("R8 ovf not a source", 32'(irq), 0);
    @(negedge clk); xfer_done = 1; @(negedge clk); xfer_done = 0;
    rd(8'h20, v); chk("R6 finish set", v, 32'h5);
    chk("R8 irq on finish", 32'(irq), 1);
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'h20; reg_wdata = 32'h1; xfer_done = 1;
    @(negedge clk);
    reg_wr = 0; xfer_done = 0;
    rd(8'h20, v); chk("R7 set beats clear", v, 32'h5);
    wr(8'h20, 32'h5); rd(8'h20, v); chk("R7 clear all", v, 0);
    chk("R8 irq off", 32'(irq), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule